// File: doc/BRIEF.md
# Ethernet Transmit Framer

This block turns a byte-wide AXI4-Stream packet into a complete frame for a GMII-style byte interface. It emits the frame one byte per clock: preamble, delimiter, the caller's bytes starting at the destination address, zero fill for short frames, and a 32-bit frame check sequence. After each frame it enforces an idle gap before the next preamble can begin. It sits between a packet source and a PHY adapter in the system clock domain.

Software-facing controls are three plain inputs. `tx_en` gates whether a new frame may begin. `jumbo_en` selects the length limit, and the framer captures it at frame start. A frame that runs past the active limit is cut at the limit and given a valid check sequence. The rest of its input is accepted and dropped, so the source never stalls. `tx_active` and a one-cycle `tx_done` pulse report progress.

The source must hold `s_axis_tvalid` high from the first accepted byte of a frame through its `tlast` byte. Frame length below counts bytes from the destination address through the check sequence.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset, `gmii_tx_en`, `gmii_txd`, `s_axis_tready`, `tx_active` and `tx_done` are all low.
- R2: Every frame opens with seven bytes of 0x55 and then one byte of 0xD5. `s_axis_tready` stays low while the seven 0x55 bytes are on the output.
- R3: Input bytes appear on `gmii_txd` in arrival order, one per clock, right after the 0xD5 byte. `gmii_tx_en` stays high from the first preamble byte through the last check-sequence byte.
- R4: When a frame has fewer than 60 input bytes, zero bytes follow the data until 60 bytes precede the check sequence, so the frame is 64 bytes long. A frame of 60 or more bytes gets no fill.
- R5: The last four bytes of each frame hold the CRC-32 of the data and fill bytes. The CRC uses the reflected polynomial 0xEDB88320 and starts from all ones. It is sent complemented, least significant byte first.
- R6: Between the last check-sequence byte and the next preamble, there are at least 12 cycles with `gmii_tx_en` low. A frame already waiting starts after exactly 12. `tx_active` is high on every cycle that `gmii_tx_en` is high and on the first 11 idle cycles after a frame.
- R7: `tx_done` is high for exactly one cycle per frame, the cycle that carries the last check-sequence byte. It is never high while `gmii_tx_en` is low.
- R8: While `tx_en` is low, no frame starts and `gmii_tx_en` stays low. Lowering `tx_en` during a frame does not cut that frame short.
- R9: The frame length is capped at `STD_FRAME` (1518) when jumbo mode is off and at `MAX_FRAME` (9018) when it is on. A longer input is cut at the cap and closed with a valid check sequence over the bytes actually sent. `s_axis_tready` is then raised again so that the remaining input bytes, through `tlast`, are consumed and dropped.
- R10: The cap is chosen from `jumbo_en` when the first preamble byte is sent. Changing `jumbo_en` during the frame does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Allows a new frame to start |
| jumbo_en | input | 1 | Selects the long-frame cap, sampled at frame start |
| s_axis_tdata | input | 8 | Frame byte from the source |
| s_axis_tvalid | input | 1 | Source byte valid |
| s_axis_tready | output | 1 | Framer accepts the byte this cycle |
| s_axis_tlast | input | 1 | Marks the final byte of a frame |
| gmii_txd | output | 8 | Byte toward the PHY adapter |
| gmii_tx_en | output | 1 | Frame byte valid on `gmii_txd` |
| tx_active | output | 1 | Framer busy with a frame or its gap |
| tx_done | output | 1 | One-cycle pulse with the final check byte |

## Verification
The hardest case to reach is the cut-off path. The framer must stop emitting at the cap, close the check sequence, and then swallow the remaining input with `gmii_tx_en` low before its gap begins. The stimulus gets there by sending frames of 1600 and 9030 bytes, and by turning jumbo mode off in the middle of a 2000-byte frame. The sender only finishes once every byte up to `tlast` has been accepted, so a stuck drain shows up. Back-to-back frames are queued with `tvalid` already high during the gap, which shows that the gap is exactly 12 cycles and not merely at least 12.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_PAD,
    ST_FCS,
    ST_DRAIN,
    ST_GAP
  } tx_state_e;

  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // One byte through the reflected CRC-32, low bit first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

  // Byte idx (0 = least significant) of the complemented remainder.
  function automatic logic [7:0] fcs_pick(input logic [31:0] c, input logic [1:0] idx);
    logic [31:0] inv;
    inv = ~c;
    return inv[{idx, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        crc_init,
  input  logic        crc_en,
  input  logic [7:0]  crc_din,
  output logic [31:0] crc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)        crc_q <= CRC_SEED;
    else if (crc_init) crc_q <= CRC_SEED;
    else if (crc_en)   crc_q <= crc_step(crc_q, crc_din);
  end

  // R5: a restart and an update never collide
  init_update_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_init && crc_en));

endmodule

// File: rtl/eth_tx_fsm.sv
module eth_tx_fsm
  import eth_tx_pkg::*;
#(
  parameter int MAX_FRAME = 9018,
  parameter int STD_FRAME = 1518,
  parameter int MIN_FRAME = 64,
  parameter int PRE_LEN   = 7,
  parameter int GAP_LEN   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        jumbo_en,
  input  logic [7:0]  s_tdata,
  input  logic        s_tvalid,
  input  logic        s_tlast,
  output logic        s_tready,
  input  logic [31:0] crc_q,
  output logic        crc_init,
  output logic        crc_en,
  output logic [7:0]  crc_din,
  output logic [7:0]  gmii_txd,
  output logic        gmii_tx_en,
  output logic        tx_active,
  output logic        tx_done
);

  localparam int FCS_LEN  = 4;
  localparam int MIN_BODY = MIN_FRAME - FCS_LEN;
  localparam int LW       = $clog2(MAX_FRAME + 1);
  localparam int CW       = $clog2(PRE_LEN + GAP_LEN + 1);
  localparam logic [LW-1:0] CAP_JUMBO = LW'(MAX_FRAME - FCS_LEN);
  localparam logic [LW-1:0] CAP_STD   = LW'(STD_FRAME - FCS_LEN);
  localparam logic [LW-1:0] BODY_MIN  = LW'(MIN_BODY);

  tx_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [LW-1:0] len_q, len_n, len_inc;
  logic [LW-1:0] cap_q, cap_n;
  logic          drain_q, drain_n;
  logic [7:0]    txd_n;
  logic          en_n, done_n;
  logic          start_ok;
  logic          take;

  // named events for the checks
  assign start_ok = (state_q == ST_IDLE) && tx_en && s_tvalid;
  assign take     = s_tready && s_tvalid;
  assign len_inc  = len_q + 1'b1;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    len_n    = len_q;
    cap_n    = cap_q;
    drain_n  = drain_q;
    txd_n    = 8'h00;
    en_n     = 1'b0;
    done_n   = 1'b0;
    s_tready = 1'b0;
    crc_init = 1'b0;
    crc_en   = 1'b0;
    crc_din  = 8'h00;
    unique case (state_q)
      ST_IDLE: begin
        crc_init = 1'b1;
        if (start_ok) begin
          txd_n   = PRE_BYTE;
          en_n    = 1'b1;
          state_n = ST_PRE;
          cnt_n   = CW'(1);
          len_n   = '0;
          drain_n = 1'b0;
          cap_n   = jumbo_en ? CAP_JUMBO : CAP_STD;
        end
      end
      ST_PRE: begin
        en_n = 1'b1;
        if (cnt_q == CW'(PRE_LEN)) begin
          txd_n   = SFD_BYTE;
          state_n = ST_DATA;
        end else begin
          txd_n = PRE_BYTE;
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        s_tready = 1'b1;
        if (s_tvalid) begin
          txd_n   = s_tdata;
          en_n    = 1'b1;
          crc_en  = 1'b1;
          crc_din = s_tdata;
          len_n   = len_inc;
          cnt_n   = '0;
          if (len_inc == cap_q) begin
            state_n = ST_FCS;
            drain_n = !s_tlast;
          end else if (s_tlast) begin
            state_n = (len_inc < BODY_MIN) ? ST_PAD : ST_FCS;
          end
        end
      end
      ST_PAD: begin
        en_n    = 1'b1;
        crc_en  = 1'b1;
        crc_din = 8'h00;
        len_n   = len_inc;
        cnt_n   = '0;
        if (len_inc == BODY_MIN) state_n = ST_FCS;
      end
      ST_FCS: begin
        en_n  = 1'b1;
        txd_n = fcs_pick(crc_q, cnt_q[1:0]);
        if (cnt_q == CW'(FCS_LEN - 1)) begin
          done_n  = 1'b1;
          cnt_n   = '0;
          state_n = drain_q ? ST_DRAIN : ST_GAP;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        s_tready = 1'b1;
        if (s_tvalid && s_tlast) begin
          state_n = ST_GAP;
          cnt_n   = '0;
          drain_n = 1'b0;
        end
      end
      ST_GAP: begin
        if (cnt_q == CW'(GAP_LEN - 1)) begin
          state_n = ST_IDLE;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      len_q      <= '0;
      cap_q      <= CAP_STD;
      drain_q    <= 1'b0;
      gmii_txd   <= 8'h00;
      gmii_tx_en <= 1'b0;
      tx_done    <= 1'b0;
    end else begin
      state_q    <= state_n;
      cnt_q      <= cnt_n;
      len_q      <= len_n;
      cap_q      <= cap_n;
      drain_q    <= drain_n;
      gmii_txd   <= txd_n;
      gmii_tx_en <= en_n;
      tx_done    <= done_n;
    end
  end

  assign tx_active = (state_q != ST_IDLE);

  // Independent idle-cycle counter for the gap guard
  logic [CW-1:0] idle_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                          idle_run <= CW'(GAP_LEN);
    else if (gmii_tx_en)                 idle_run <= '0;
    else if (idle_run != CW'(GAP_LEN))   idle_run <= idle_run + 1'b1;
  end

  // R2
  preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gmii_tx_en) |-> (gmii_txd == PRE_BYTE));

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAD) |=> (gmii_tx_en && gmii_txd == 8'h00));

  // R6
  gap_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> (!gmii_tx_en && idle_run >= CW'(GAP_LEN - 1)));

  // R7
  done_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> gmii_tx_en);

  // R7
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (!gmii_tx_en && !tx_done));

  // R8
  start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gmii_tx_en) |-> $past(tx_en));

  // R9
  body_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q <= cap_q));

  // R9
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |=> !gmii_tx_en);

  // R10
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(cap_q));

  // R3
  ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (gmii_tx_en || $past(state_q) == ST_DRAIN));

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int MAX_FRAME = 9018,
  parameter int STD_FRAME = 1518,
  parameter int MIN_FRAME = 64,
  parameter int PRE_LEN   = 7,
  parameter int GAP_LEN   = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       jumbo_en,
  input  logic [7:0] s_axis_tdata,
  input  logic       s_axis_tvalid,
  output logic       s_axis_tready,
  input  logic       s_axis_tlast,
  output logic [7:0] gmii_txd,
  output logic       gmii_tx_en,
  output logic       tx_active,
  output logic       tx_done
);

  logic [31:0] crc_q;
  logic        crc_init;
  logic        crc_en;
  logic [7:0]  crc_din;

  eth_tx_crc u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .crc_init (crc_init),
    .crc_en   (crc_en),
    .crc_din  (crc_din),
    .crc_q    (crc_q)
  );

  eth_tx_fsm #(
    .MAX_FRAME (MAX_FRAME),
    .STD_FRAME (STD_FRAME),
    .MIN_FRAME (MIN_FRAME),
    .PRE_LEN   (PRE_LEN),
    .GAP_LEN   (GAP_LEN)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .jumbo_en   (jumbo_en),
    .s_tdata    (s_axis_tdata),
    .s_tvalid   (s_axis_tvalid),
    .s_tlast    (s_axis_tlast),
    .s_tready   (s_axis_tready),
    .crc_q      (crc_q),
    .crc_init   (crc_init),
    .crc_en     (crc_en),
    .crc_din    (crc_din),
    .gmii_txd   (gmii_txd),
    .gmii_tx_en (gmii_tx_en),
    .tx_active  (tx_active),
    .tx_done    (tx_done)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!gmii_tx_en && !tx_done && !s_axis_tready && !tx_active));

endmodule

// File: tb/eth_tx_framer_test.sv
`timescale 1ns/1ps
module eth_tx_framer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b1;
  logic       jumbo_en = 1'b0;
  logic [7:0] tdata = 8'h00;
  logic       tvalid = 1'b0;
  logic       tlast = 1'b0;
  logic       tready;
  logic [7:0] gmii_txd;
  logic       gmii_tx_en;
  logic       tx_active;
  logic       tx_done;

  always #2.5 clk = ~clk;

  eth_tx_framer uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_en         (tx_en),
    .jumbo_en      (jumbo_en),
    .s_axis_tdata  (tdata),
    .s_axis_tvalid (tvalid),
    .s_axis_tready (tready),
    .s_axis_tlast  (tlast),
    .gmii_txd      (gmii_txd),
    .gmii_tx_en    (gmii_tx_en),
    .tx_active     (tx_active),
    .tx_done       (tx_done)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- output monitor ----------------
  logic [7:0] cap [0:9299];
  int n = 0;
  int frame_len = 0;
  int frames_seen = 0;
  int idle_run = 0;
  int last_gap = 0;
  int done_at = 0;
  int done_cnt = 0;
  int stray_done = 0;
  int act_bad = 0;
  int pre_ready_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (gmii_tx_en) begin
        if (n == 0) last_gap = idle_run;
        cap[n] = gmii_txd;
        if (tx_done) begin done_at = n + 1; done_cnt++; end
        if (!tx_active) act_bad++;
        if (n < 7 && tready) pre_ready_bad++;
        n++;
        idle_run = 0;
      end else begin
        if (n > 0) begin
          frame_len = n;
          n = 0;
          frames_seen++;
        end
        if (tx_done) stray_done++;
        if (frames_seen > 0 && idle_run < 11 && !tx_active) act_bad++;
        idle_run++;
      end
    end
  end

  // ---------------- reference model ----------------
  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'((seed * 37) + (i * 11) + (i >> 8));
  endfunction

  function automatic logic [31:0] ref_crc_bit(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ b[k];
      r = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  task automatic check_frame(input string tag, input int in_len, input int seed, input int cap_len);
    int p, body, errs_pre, errs_dat, errs_pad, errs_fcs;
    logic [31:0] c;
    logic [7:0] e;
    p = (in_len < cap_len - 4) ? in_len : cap_len - 4;
    body = (p < 60) ? 60 : p;
    check(frame_len == 8 + body + 4, $sformatf("R9/R4 length %s", tag), frame_len, 8 + body + 4);
    errs_pre = 0;
    for (int i = 0; i < 7; i++) if (cap[i] != 8'h55) errs_pre++;
    if (cap[7] != 8'hD5) errs_pre++;
    check(errs_pre == 0, $sformatf("R2 preamble %s", tag), errs_pre, 0);
    check(pre_ready_bad == 0, $sformatf("R2 ready low %s", tag), pre_ready_bad, 0);
    errs_dat = 0; errs_pad = 0;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < body; i++) begin
      e = (i < p) ? pay(seed, i) : 8'h00;
      if (i < p && cap[8 + i] != e) errs_dat++;
      if (i >= p && cap[8 + i] != e) errs_pad++;
      c = ref_crc_bit(c, e);
    end
    check(errs_dat == 0, $sformatf("R3 payload %s", tag), errs_dat, 0);
    check(errs_pad == 0, $sformatf("R4 padding %s", tag), errs_pad, 0);
    c = ~c;
    errs_fcs = 0;
    for (int k = 0; k < 4; k++) if (cap[8 + body + k] != c[8*k +: 8]) errs_fcs++;
    check(errs_fcs == 0, $sformatf("R5 fcs %s", tag), errs_fcs, 0);
    check(done_at == frame_len, $sformatf("R7 done position %s", tag), done_at, frame_len);
    check(act_bad == 0 && stray_done == 0, $sformatf("R6/R7 activity %s", tag), act_bad + stray_done, 0);
    pre_ready_bad = 0;
  endtask

  // ---------------- source driver ----------------
  task automatic send_frame(input int len, input int seed, input int flip_at);
    int i;
    @(negedge clk);
    i = 0;
    while (i < len) begin
      tdata  = pay(seed, i);
      tvalid = 1'b1;
      tlast  = (i == len - 1);
      if (i == flip_at) jumbo_en = 1'b0;
      if (tready) i++;
      @(negedge clk);
    end
    tvalid = 1'b0;
    tlast  = 1'b0;
  endtask

  task automatic run_one(input string tag, input int len, input int seed, input int cap_len);
    int k;
    int d0;
    k = frames_seen + 1;
    d0 = done_cnt;
    send_frame(len, seed, -1);
    wait (frames_seen >= k);
    check_frame(tag, len, seed, cap_len);
    check(done_cnt == d0 + 1, $sformatf("R7 one pulse %s", tag), done_cnt - d0, 1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(!gmii_tx_en && gmii_txd == 8'h00, "R1 output idle", gmii_tx_en, 0);
    check(!tready && !tx_active && !tx_done, "R1 status low", {tready, tx_active, tx_done}, 0);
  endtask

  task automatic t_short();
    run_one("short10", 10, 1, 1518);
    run_one("one byte", 1, 2, 1518);
  endtask

  task automatic t_exact();
    run_one("exact60", 60, 3, 1518);
    run_one("len59", 59, 4, 1518);
    run_one("len300", 300, 5, 1518);
  endtask

  task automatic t_back2back();
    int k;
    k = frames_seen + 1;
    fork
      begin
        send_frame(20, 6, -1);
        send_frame(200, 7, -1);
      end
    join_none
    wait (frames_seen >= k);
    check_frame("b2b first", 20, 6, 1518);
    wait (frames_seen >= k + 1);
    check(last_gap == 12, "R6 back-to-back gap", last_gap, 12);
    check_frame("b2b second", 200, 7, 1518);
  endtask

  task automatic t_gate();
    int k;
    int n0;
    bit saw;
    k = frames_seen;
    tx_en = 1'b0;
    fork
      send_frame(30, 8, -1);
    join_none
    saw = 0;
    repeat (40) begin
      @(negedge clk);
      if (gmii_tx_en || tready) saw = 1;
    end
    check(!saw && frames_seen == k, "R8 held while disabled", saw, 0);
    tx_en = 1'b1;
    wait (frames_seen >= k + 1);
    check_frame("after enable", 30, 8, 1518);
    repeat (20) @(negedge clk);
    n0 = frames_seen;
    fork
      send_frame(80, 9, -1);
    join_none
    wait (gmii_tx_en);
    repeat (15) @(negedge clk);
    tx_en = 1'b0;
    wait (frames_seen >= n0 + 1);
    check_frame("disable mid-frame", 80, 9, 1518);
    tx_en = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_oversize();
    run_one("std cut 1600", 1600, 10, 1518);
    check(idle_run >= 12, "R9 drain then gap", idle_run, 12);
    repeat (20) @(negedge clk);
    jumbo_en = 1'b1;
    run_one("jumbo cap 9030", 9030, 11, 9018);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_latch();
    int k;
    k = frames_seen + 1;
    jumbo_en = 1'b1;
    send_frame(2000, 12, 100);
    wait (frames_seen >= k);
    check_frame("R10 jumbo sampled at start", 2000, 12, 9018);
    repeat (20) @(negedge clk);
    k = frames_seen + 1;
    send_frame(1600, 13, -1);
    wait (frames_seen >= k);
    check_frame("R10 jumbo off next frame", 1600, 13, 1518);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_exact();
    t_back2back();
    t_gate();
    t_oversize();
    t_latch();
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule